// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block sits in the next-PC path of a seven-stage pipelined core (PIF, IF, ID, EX, PDF, DF, WB). It decides in the EX stage, where the coprocessor lives, whether an asynchronous interrupt is taken. Its inputs are the coprocessor's pending-and-enabled request, the validity and branch/jump status of the instruction now in EX, the pipeline stall, and the sequential address of the instruction that would run next.

When it takes an interrupt, the instruction in EX completes normally. In that same cycle the block does four things:
- redirects the PC to the single service-routine vector;
- writes the follow-on address into the exception PC register;
- pulses a clear of the global interrupt enable;
- squashes the three younger stages PIF, IF and ID.

A branch or jump that advances out of EX arms a deferral window that covers the three slots behind it: the delay slot and the two killed slots. Acceptance is held off until all three have left EX. This means a return through the saved address can never skip the control transfer.

Return needs no dedicated instruction. Software reads the saved address, jumps to it, and re-enables interrupts in the delay slot of that jump.

Top module: `irq_entry_seq`

## Requirements
- R1: During synchronous active-low reset, and in the first cycle after it, no output strobe is asserted unless a request is taken. The deferral window starts closed, so a request seen in the first cycle after reset is accepted.
- R2: A request is taken in a cycle only when all of these hold in that cycle: `irq_req`=1, `ex_valid`=1, `stall`=0, the instruction in EX is not a branch/jump, and the deferral window is closed. In that cycle `pc_redirect`=1 and `pc_target`=VECTOR (default 0x0040_000C).
- R3: In the cycle a request is taken, `epc_we`=1 and `epc_data` equals `ex_next_pc` of that cycle. In any other cycle `epc_we`=0.
- R4: `ie_clear` is 1 exactly in the cycles where a request is taken.
- R5: `flush_pif`, `flush_if` and `flush_id` are each 1 exactly in the cycles where a request is taken.
- R6: No request is taken in a cycle whose EX instruction is a valid branch/jump (`ex_valid`=1 and `ex_is_xfer`=1).
- R7: After a valid branch/jump leaves EX in an unstalled cycle, the next 3 unstalled cycles cannot take a request. The 4th unstalled cycle after it can.
- R8: A cycle with `stall`=1 takes no request and does not count toward the deferral window.
- R9: A valid branch/jump that leaves EX while the window is still open restarts the window at the full 3 unstalled cycles.
- R10: With `irq_req`=0 or `ex_valid`=0, no request is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | 1 | Pending-and-enabled interrupt request from the coprocessor |
| ex_valid | input | 1 | EX holds a real instruction |
| ex_is_xfer | input | 1 | EX instruction is a branch or jump |
| stall | input | 1 | Pipeline stalled this cycle |
| ex_next_pc | input | AW | Sequential address of the next instruction |
| pc_redirect | output | 1 | Load the PC with `pc_target` |
| pc_target | output | AW | Service-routine vector |
| epc_we | output | 1 | Write strobe for the exception PC register |
| epc_data | output | AW | Return address to store |
| ie_clear | output | 1 | Clear the global interrupt enable |
| flush_pif | output | 1 | Squash the PIF slot |
| flush_if | output | 1 | Squash the IF slot |
| flush_id | output | 1 | Squash the ID slot |

## Verification
The bench sweeps a long pseudo-random mix of request, valid, branch and stall patterns and compares every output with an arithmetic count of the unstalled cycles since the last branch/jump. It also runs directed cases:
- a request held across a branch and its three following slots, which catches an off-by-one window;
- stalls inside the window, which catches a design that counts stalled cycles;
- a second branch inside the window, which catches a missing reload.

Each of these faults would let the core save a return address past an untaken transfer. A design that took the request on the branch itself would save the delay-slot address, so the return would lose the jump. Each strobe is checked on its own, so an EPC write or enable clear that drifts off the redirect cycle is also reported.

// File: rtl/irq_entry_pkg.sv
// Package: shared constants for the interrupt entry sequencer.
// Assumes a byte-addressed core whose addresses are at most 32 bits wide.
package irq_entry_pkg;
    localparam int unsigned DEF_AW     = 32;
    localparam logic [31:0] DEF_VECTOR = 32'h0040_000C;
    localparam int unsigned DEF_SLOTS  = 3;
    localparam int unsigned NUM_FLUSH  = 3;
    // Indices into the squash vector, ordered from the oldest younger stage.
    localparam int unsigned FL_ID  = 0;
    localparam int unsigned FL_IF  = 1;
    localparam int unsigned FL_PIF = 2;
endpackage

// File: rtl/irq_defer_cnt.sv
// Module: deferral window counter.
// It reloads to SLOTS when a valid branch/jump leaves EX unstalled.
// It counts down once per further unstalled cycle.
// win_closed is high when the counter reaches zero.
// Assumes stall freezes every slot, including EX.
module irq_defer_cnt #(
    parameter int unsigned SLOTS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic advance,
    input  logic xfer_adv,
    output logic win_closed
);
    localparam int unsigned CW = $clog2(SLOTS + 1);
    localparam logic [CW-1:0] LOADV = CW'(SLOTS);

    logic [CW-1:0] cnt;

    // Reload on a leaving transfer; otherwise count down on each advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (xfer_adv) begin
            cnt <= LOADV;
        end else if (advance && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    // Window is closed once every deferred slot has left EX.
    always_comb win_closed = (cnt == '0);

    p_reload_r9: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_adv |=> (cnt == LOADV));
    p_count_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !xfer_adv && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
    p_hold_on_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!advance && !xfer_adv) |=> $stable(cnt));
endmodule

// File: rtl/irq_accept.sv
// Module: acceptance gate.
// It takes a request only when the current EX instruction can complete
// and be the last one before the vector.
// Assumes irq_req already includes the global enable and the source masks.
module irq_accept (
    input  logic rst_n,
    input  logic irq_req,
    input  logic ex_valid,
    input  logic ex_is_xfer,
    input  logic stall,
    input  logic win_closed,
    output logic take
);
    logic slot_ok;

    // EX must hold a non-transfer instruction that retires this cycle.
    always_comb slot_ok = ex_valid && !ex_is_xfer && !stall;

    // Final decision: request present, slot usable, window closed.
    always_comb take = rst_n && irq_req && slot_ok && win_closed;
endmodule

// File: rtl/irq_redirect_out.sv
// Module: entry action generator.
// It fans one take pulse out to the PC redirect, the EPC write,
// the enable clear and the per-stage squash lines, all in one cycle.
// Assumes the consumers sample these strobes at the next clock edge.
module irq_redirect_out #(
    parameter int unsigned AW     = 32,
    parameter logic [AW-1:0] VECTOR = '0,
    parameter int unsigned NFLUSH = 3
) (
    input  logic              take,
    input  logic [AW-1:0]     next_pc,
    output logic              redirect,
    output logic [AW-1:0]     target,
    output logic              epc_we,
    output logic [AW-1:0]     epc_data,
    output logic              ie_clear,
    output logic [NFLUSH-1:0] flush
);
    // PC side: the vector is fixed, and the redirect follows take.
    always_comb begin
        redirect = take;
        target   = VECTOR;
    end

    // Status side: save the return address and drop the enable.
    always_comb begin
        epc_we   = take;
        epc_data = next_pc;
        ie_clear = take;
    end

    // One squash line per younger stage.
    for (genvar g = 0; g < NFLUSH; g++) begin : g_flush
        always_comb flush[g] = take;
    end
endmodule

// File: rtl/irq_entry_seq.sv
// Module: interrupt entry sequencer (top).
// Placed at EX, it decides whether an interrupt is taken this cycle.
// When it is, it redirects to the vector, saves the return address,
// clears the enable and squashes PIF, IF and ID.
// Assumes ex_next_pc is the address that would follow the EX instruction.
module irq_entry_seq
    import irq_entry_pkg::*;
#(
    parameter int unsigned AW     = DEF_AW,
    parameter logic [AW-1:0] VECTOR = AW'(DEF_VECTOR),
    parameter int unsigned SLOTS  = DEF_SLOTS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          irq_req,
    input  logic          ex_valid,
    input  logic          ex_is_xfer,
    input  logic          stall,
    input  logic [AW-1:0] ex_next_pc,
    output logic          pc_redirect,
    output logic [AW-1:0] pc_target,
    output logic          epc_we,
    output logic [AW-1:0] epc_data,
    output logic          ie_clear,
    output logic          flush_pif,
    output logic          flush_if,
    output logic          flush_id
);
    logic advance;
    logic xfer_adv;
    logic win_closed;
    logic take;
    logic [NUM_FLUSH-1:0] flush;

    // Slot movement through EX and a leaving branch/jump.
    always_comb begin
        advance  = !stall;
        xfer_adv = ex_valid && ex_is_xfer && !stall;
    end

    irq_defer_cnt #(.SLOTS(SLOTS)) u_defer (
        .clk        (clk),
        .rst_n      (rst_n),
        .advance    (advance),
        .xfer_adv   (xfer_adv),
        .win_closed (win_closed)
    );

    irq_accept u_accept (
        .rst_n      (rst_n),
        .irq_req    (irq_req),
        .ex_valid   (ex_valid),
        .ex_is_xfer (ex_is_xfer),
        .stall      (stall),
        .win_closed (win_closed),
        .take       (take)
    );

    irq_redirect_out #(.AW(AW), .VECTOR(VECTOR), .NFLUSH(NUM_FLUSH)) u_out (
        .take     (take),
        .next_pc  (ex_next_pc),
        .redirect (pc_redirect),
        .target   (pc_target),
        .epc_we   (epc_we),
        .epc_data (epc_data),
        .ie_clear (ie_clear),
        .flush    (flush)
    );

    // Name the squash lines by stage.
    always_comb begin
        flush_pif = flush[FL_PIF];
        flush_if  = flush[FL_IF];
        flush_id  = flush[FL_ID];
    end

    p_stall_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> !pc_redirect);
    p_xfer_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid && ex_is_xfer) |-> !pc_redirect);
    p_need_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pc_redirect |-> (irq_req && ex_valid));
    p_epc_with_redirect_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pc_redirect |-> (epc_we && epc_data == ex_next_pc));
    p_ie_with_redirect_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pc_redirect |-> ie_clear);
    p_flush_with_redirect_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pc_redirect |-> (flush_pif && flush_if && flush_id));
    p_after_xfer_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid && ex_is_xfer && !stall) |=> !pc_redirect);
endmodule

// File: tb/irq_entry_seq_bench.sv
module irq_entry_seq_bench;
    localparam int unsigned AW = 32;
    localparam logic [31:0] VEC = 32'h0040_000C;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic irq_req = 1'b0, ex_valid = 1'b0, ex_is_xfer = 1'b0, stall = 1'b0;
    logic [AW-1:0] ex_next_pc = '0;
    logic pc_redirect, epc_we, ie_clear, flush_pif, flush_if, flush_id;
    logic [AW-1:0] pc_target, epc_data;

    int checks = 0;
    int errors = 0;
    int since = 3;
    logic [15:0] lfsr = 16'hACE1;

    always #2 clk = ~clk;

    irq_entry_seq u_irq_entry_seq (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .ex_valid(ex_valid),
        .ex_is_xfer(ex_is_xfer), .stall(stall), .ex_next_pc(ex_next_pc),
        .pc_redirect(pc_redirect), .pc_target(pc_target), .epc_we(epc_we),
        .epc_data(epc_data), .ie_clear(ie_clear), .flush_pif(flush_pif),
        .flush_if(flush_if), .flush_id(flush_id)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Drive one cycle after the falling edge, check, then advance the model.
    task automatic cyc(input logic i, input logic v, input logic x, input logic s,
                       input logic [31:0] pc);
        logic exp_take;
        string tag;
        @(negedge clk);
        irq_req = i; ex_valid = v; ex_is_xfer = x; stall = s; ex_next_pc = pc;
        #1;
        exp_take = rst_n && i && v && !x && !s && (since >= 3);
        if (!rst_n)            tag = "R1";
        else if (!i || !v)     tag = "R10";
        else if (s)            tag = "R8";
        else if (x)            tag = "R6";
        else if (since < 3)    tag = "R7";
        else                   tag = "R2";
        chk(tag, {31'b0, pc_redirect}, {31'b0, exp_take});
        chk("R3", {31'b0, epc_we}, {31'b0, exp_take});
        if (exp_take) begin
            chk("R2", pc_target, VEC);
            chk("R3", epc_data, pc);
        end
        chk("R4", {31'b0, ie_clear}, {31'b0, exp_take});
        chk("R5", {29'b0, flush_pif, flush_if, flush_id}, exp_take ? 32'd7 : 32'd0);
        if (!rst_n)          since = 3;
        else if (v && x && !s) since = 0;
        else if (!s && since < 3) since++;
    endtask

    initial begin
        #800000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1: reset holds every strobe low even with a request present.
        cyc(1, 1, 0, 0, 32'h100);
        cyc(1, 1, 0, 0, 32'h104);
        rst_n = 1'b1;
        // R1 and R2: the first cycle after reset accepts a request.
        cyc(1, 1, 0, 0, 32'h200);
        // R6 and R7: a request held across a branch and its three slots.
        cyc(1, 1, 1, 0, 32'h204);
        cyc(1, 1, 0, 0, 32'h208);
        cyc(1, 0, 0, 0, 32'h20C);
        cyc(1, 0, 0, 0, 32'h210);
        cyc(1, 1, 0, 0, 32'h300);
        // R8: stalls inside the window do not count toward it.
        cyc(0, 1, 1, 0, 32'h304);
        cyc(1, 1, 0, 1, 32'h308);
        cyc(1, 1, 0, 0, 32'h308);
        cyc(1, 1, 0, 1, 32'h30C);
        cyc(1, 1, 0, 1, 32'h30C);
        cyc(1, 1, 0, 0, 32'h30C);
        cyc(1, 1, 0, 0, 32'h310);
        cyc(1, 1, 0, 0, 32'h314);
        // R9: a second branch inside the window restarts it.
        cyc(0, 1, 1, 0, 32'h400);
        cyc(0, 1, 0, 0, 32'h404);
        cyc(0, 1, 1, 0, 32'h500);
        cyc(1, 1, 0, 0, 32'h504);
        cyc(1, 1, 0, 0, 32'h508);
        cyc(1, 1, 0, 0, 32'h50C);
        cyc(1, 1, 0, 0, 32'h510);
        // R10: no request, or an invalid EX slot, takes nothing.
        cyc(0, 1, 0, 0, 32'h600);
        cyc(1, 0, 0, 0, 32'h604);
        // Sweep over pseudo-random mixes of all four control inputs.
        for (int n = 0; n < 4000; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            cyc(lfsr[0] | lfsr[5], lfsr[1] | lfsr[6], lfsr[2] & lfsr[7],
                lfsr[3] & lfsr[8], {lfsr, lfsr[15:2], 2'b00});
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule